// File: doc/BRIEF.md
# Stereo Serial Audio Port Receiver

This block receives two-channel serial audio and delivers each stereo frame as a pair of 24-bit two's complement words with a one-cycle strobe. It runs entirely on the master clock (`clk`). In slave mode the bit clock and word-select clock arrive on pins. The block samples them through a synchronizer and detects bit-clock rising edges, so each bit-clock phase must last at least two `clk` cycles. In master mode the block makes both clocks itself from a counter of 128 clock ticks per frame: 64 bit clocks per frame and a sample rate of the tick rate divided by 128.

A divide-by-two option slows the tick to every other `clk` cycle, which halves the effective master clock ahead of the generator. In master mode the generated clocks are also driven out with a shared output enable. A bus-release input drops that enable so another source can drive the shared lines, and reception continues on the internal clocks. Two framings are supported: the delayed-MSB format (I2S) and the left-justified format. Words shorter than 24 bits are padded with zeros at the bottom. Bits after the 24th in a slot are dropped. A stereo frame is published only when both of its slots began at a word-select edge that the block saw.

Configuration inputs are expected to change only while reset is held.

Top module: `audio_serial_rx`

## Requirements
- R1: In master mode with `mclk_div2`=0, `sclk_out` has a period of 2 `clk` cycles, and `lrck_out` changes every 64 `clk` cycles, only on the cycle in which `sclk_out` falls.
- R2: In master mode with `mclk_div2`=1, every period of the generator doubles: `sclk_out` has a period of 4 `clk` cycles and `lrck_out` changes every 128 `clk` cycles.
- R3: `clk_oe` is 1 only when `master_en`=1 and `bus_hiz`=0; in slave mode it is 0.
- R4: With `fmt_lj`=0 (I2S), word select low marks the left slot, and the MSB is the bit sampled on the second SCLK rising edge after a word-select change. For a 24-bit slot, the LSB therefore arrives on the first rising edge of the next slot.
- R5: With `fmt_lj`=1 (left-justified), word select high marks the left slot, and the MSB is the bit sampled on the first SCLK rising edge after a word-select change.
- R6: Bits of a slot after the 24th data bit have no effect on the captured word.
- R7: A slot carrying N<24 data bits yields the N bits in the top positions and zeros in the 24-N low bits.
- R8: `sample_valid` is a one-cycle pulse, raised once per received stereo frame after its right slot ends. `left_data` and `right_data` change only in that cycle.
- R9: While reset is held, `sample_valid`, `left_data`, `right_data` and `sclk_out` are 0.
- R10: A slot that was not opened by an observed word-select edge is discarded. In master mode the first frame after reset is never published, and the first pulse comes about 256 ticks after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1: generate bit/word clocks; 0: take them from pins |
| mclk_div2 | input | 1 | 1: halve the master clock ahead of the generator |
| fmt_lj | input | 1 | 0: I2S framing; 1: left-justified framing |
| bus_hiz | input | 1 | 1: release the generated clock lines in master mode |
| sclk_in | input | 1 | Bit clock from the bus (slave mode) |
| lrck_in | input | 1 | Word-select clock from the bus (slave mode) |
| sdin | input | 1 | Serial audio data |
| sclk_out | output | 1 | Generated bit clock |
| lrck_out | output | 1 | Generated word-select clock |
| clk_oe | output | 1 | Output enable for `sclk_out` and `lrck_out` |
| left_data | output | 24 | Last received left word |
| right_data | output | 24 | Last received right word |
| sample_valid | output | 1 | One-cycle strobe for a new stereo frame |

## Verification
In I2S framing, a single SCLK rising edge at a word-select change both finishes the ending word and opens the next slot. When the slot is 24 bits or shorter, that edge also carries the last data bit of the ending word. The bench provokes this with slave streams of 24-bit and 16-bit slots, where the LSB of every word lands on the edge that opens the next slot. It judges the case by comparing each published pair, bit for bit, with the sent words masked to the slot length. Junk bits after the 24th in 32-bit slots confirm that the same edge leaves the finished word untouched when the slot is long.

// File: rtl/asp_pkg.sv
// Package: shared types for the serial audio port receiver.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package asp_pkg;

    // Framing selector: delayed-MSB (I2S) or left-justified.
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } asp_fmt_e;

    // One bit-clock rising edge as seen by the deframer.
    typedef struct packed {
        logic rise;   // an SCLK rising edge occurred
        logic lr;     // word-select level at that edge
        logic dat;    // data bit sampled at that edge
    } asp_evt_t;

endpackage

// File: rtl/asp_clkgen.sv
// Module: asp_clkgen
// Generates the master-mode bit clock and word-select clock from a tick
// counter. One frame is FRAME_TICKS ticks; the bit clock is ticks/2 and
// word select is the counter MSB, inverted for left-justified framing so
// that the first half-frame is always the left slot. A tick is every clk
// cycle, or every second cycle when div2 is set.
// Assumes: FRAME_TICKS is a power of two; div2 and fmt change only in reset.
module asp_clkgen
    import asp_pkg::*;
#(
    parameter int FRAME_TICKS = 128
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     div2,
    input  asp_fmt_e fmt,
    output logic     sclk_o,
    output logic     lrck_o,
    output logic     rise_o
);
    localparam int CNT_W = $clog2(FRAME_TICKS);

    logic             ph_q;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;

    // Tick phase: alternates under div2, otherwise parked at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= div2 ? ~ph_q : 1'b0;
    end

    assign tick = ~div2 | ph_q;

    // Frame counter: advances one step per tick, wraps each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    assign sclk_o = cnt_q[0];
    assign lrck_o = cnt_q[CNT_W-1] ^ (fmt == FMT_LJ);
    assign rise_o = tick & ~cnt_q[0];

    AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(fmt) && !$stable(lrck_o)) |-> $fell(sclk_o)); // R1

    AST_DIV2_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (div2 && $past(div2) && $past(div2, 2) && $rose(sclk_o)) |-> !$past(sclk_o, 2)); // R2

endmodule

// File: rtl/asp_frontend.sv
// Module: asp_frontend
// Turns either the generated clocks (master) or the pin clocks (slave)
// into one registered stream of bit events. Slave pins pass a
// SYNC_STAGES-deep synchronizer and a rising edge is found by comparing
// with the previous synchronized bit clock. In master mode data is taken
// straight from the pin on the cycle the generated bit clock rises.
// Assumes: slave SCLK phases last at least two clk cycles; SYNC_STAGES >= 2.
module asp_frontend
    import asp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     master,
    input  logic     sclk_pin,
    input  logic     lrck_pin,
    input  logic     sdin,
    input  logic     gen_rise,
    input  logic     gen_lrck,
    output asp_evt_t ev_o
);
    logic [SYNC_STAGES-1:0][2:0] sync_q;
    logic                        sclk_prev_q;
    logic [2:0]                  pins_s;
    asp_evt_t                    ev_d;

    // Synchronizer: shifts {sclk, lrck, sdin} through SYNC_STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= {sclk_pin, lrck_pin, sdin};
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    assign pins_s = sync_q[SYNC_STAGES-1];

    // Edge memory: last synchronized bit-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= pins_s[2];
    end

    // Source select between generated and pin clocks.
    always_comb begin
        if (master) begin
            ev_d.rise = gen_rise;
            ev_d.lr   = gen_lrck;
            ev_d.dat  = sdin;
        end else begin
            ev_d.rise = pins_s[2] & ~sclk_prev_q;
            ev_d.lr   = pins_s[1];
            ev_d.dat  = pins_s[0];
        end
    end

    // Event register: one registered event per bit-clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_o <= '0;
        else        ev_o <= ev_d;
    end

    AST_EV_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o.rise |=> (!ev_o.rise || !$stable(master))); // R4

endmodule

// File: rtl/asp_deframer.sv
// Module: asp_deframer
// Builds words from bit events. A change of word select between two
// events opens a new slot; the slot position then selects which bit of
// the 24-bit word the event fills (MSB at position 0 for left-justified,
// position 1 for I2S). At each slot opening the finished word is filed as
// left or right by its word-select level; a right word completing a left
// word that was itself properly opened publishes the pair.
// Assumes: events are at least two cycles apart.
module asp_deframer
    import asp_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int POS_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  asp_fmt_e          fmt,
    input  asp_evt_t          ev,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);
    localparam int K_W = POS_W + 2;

    logic              have_prev_q, prev_lr_q, slot_ok_q, left_ok_q;
    logic [POS_W-1:0]  pos_q;
    logic [WORD_W-1:0] word_q, left_hold_q;
    logic              lj, left_lvl, edge_c, prev_left;
    logic [K_W-1:0]    k_cont;
    logic [WORD_W-1:0] word_cont, word_fin, word_fresh;
    logic [POS_W-1:0]  pos_inc;

    // Write bit b at data index k (0 = MSB); indexes past the word are dropped.
    function automatic logic [WORD_W-1:0] put_bit(input logic [WORD_W-1:0] w,
                                                  input logic [K_W-1:0] k,
                                                  input logic b);
        logic [WORD_W-1:0] r;
        r = w;
        for (int i = 0; i < WORD_W; i++) begin
            if (k == K_W'(WORD_W - 1 - i)) r[i] = b;
        end
        return r;
    endfunction

    // Slot decode: edge detection, bit index and the candidate words.
    always_comb begin
        lj         = (fmt == FMT_LJ);
        left_lvl   = lj;
        edge_c     = ev.rise && have_prev_q && (ev.lr != prev_lr_q);
        prev_left  = (prev_lr_q == left_lvl);
        k_cont     = lj ? K_W'(pos_q) + 1'b1 : K_W'(pos_q);
        word_cont  = put_bit(word_q, k_cont, ev.dat);
        word_fin   = lj ? word_q : word_cont;
        word_fresh = lj ? {ev.dat, {(WORD_W-1){1'b0}}} : '0;
        pos_inc    = (pos_q == '1) ? pos_q : pos_q + 1'b1;
    end

    // Slot tracker: position, word assembly and word-select memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev_q <= 1'b0;
            prev_lr_q   <= 1'b0;
            slot_ok_q   <= 1'b0;
            pos_q       <= '0;
            word_q      <= '0;
        end else if (ev.rise) begin
            have_prev_q <= 1'b1;
            prev_lr_q   <= ev.lr;
            if (edge_c) begin
                slot_ok_q <= 1'b1;
                pos_q     <= '0;
                word_q    <= word_fresh;
            end else begin
                pos_q     <= pos_inc;
                word_q    <= word_cont;
            end
        end
    end

    // Pairing and publish: files finished words and strobes complete frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_ok_q   <= 1'b0;
            left_hold_q <= '0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (edge_c) begin
                if (prev_left) begin
                    left_ok_q   <= slot_ok_q;
                    left_hold_q <= word_fin;
                end else begin
                    left_ok_q <= 1'b0;
                    if (slot_ok_q && left_ok_q) begin
                        left_o  <= left_hold_q;
                        right_o <= word_fin;
                        valid_o <= 1'b1;
                    end
                end
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R8

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o))); // R8

    AST_PUBLISH_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(ev.rise) && $past(have_prev_q))); // R10

endmodule

// File: rtl/audio_serial_rx.sv
// Module: audio_serial_rx (top)
// Stereo serial audio port receiver with master or slave clocking,
// a master-clock divide-by-two, releasable clock outputs and I2S or
// left-justified framing. Outputs one 24-bit word per channel per frame.
// Assumes: configuration inputs are changed only while rst_n is low.
module audio_serial_rx
    import asp_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int FRAME_TICKS = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              mclk_div2,
    input  logic              fmt_lj,
    input  logic              bus_hiz,
    input  logic              sclk_in,
    input  logic              lrck_in,
    input  logic              sdin,
    output logic              sclk_out,
    output logic              lrck_out,
    output logic              clk_oe,
    output logic [WORD_W-1:0] left_data,
    output logic [WORD_W-1:0] right_data,
    output logic              sample_valid
);
    localparam int SLOT_SCLKS = FRAME_TICKS / 4;
    localparam int POS_W      = $clog2(SLOT_SCLKS) + 1;

    asp_fmt_e fmt;
    logic     gen_rise;
    asp_evt_t ev;

    assign fmt    = asp_fmt_e'(fmt_lj);
    assign clk_oe = master_en & ~bus_hiz;

    asp_clkgen #(.FRAME_TICKS(FRAME_TICKS)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .div2   (mclk_div2),
        .fmt    (fmt),
        .sclk_o (sclk_out),
        .lrck_o (lrck_out),
        .rise_o (gen_rise)
    );

    asp_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_frontend (
        .clk      (clk),
        .rst_n    (rst_n),
        .master   (master_en),
        .sclk_pin (sclk_in),
        .lrck_pin (lrck_in),
        .sdin     (sdin),
        .gen_rise (gen_rise),
        .gen_lrck (lrck_out),
        .ev_o     (ev)
    );

    asp_deframer #(.WORD_W(WORD_W), .POS_W(POS_W)) u_deframer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt     (fmt),
        .ev      (ev),
        .left_o  (left_data),
        .right_o (right_data),
        .valid_o (sample_valid)
    );

    AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hiz || !master_en) |-> !clk_oe); // R3

endmodule

// File: tb/sim_audio_serial_rx.sv
// Bench for audio_serial_rx: random words from a fixed seed plus directed
// slot lengths, checked against expected words computed here.
module sim_audio_serial_rx;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0, mclk_div2 = 1'b0, fmt_lj = 1'b0, bus_hiz = 1'b0;
    logic        sclk_in = 1'b0, lrck_in = 1'b0, sdin = 1'b0;
    logic        sclk_out, lrck_out, clk_oe, sample_valid;
    logic [23:0] left_data, right_data;

    int          n_chk = 0, n_bad = 0;
    logic [23:0] txL [8], txR [8], expL [8], expR [8];
    int          rx_idx = 0;
    bit          mon_on = 1'b0, prev_v = 1'b0, tx_run = 1'b0, carry = 1'b0;
    string       mon_req = "R4";
    time         first_t = 0, rel_t = 0;

    always #(CLK_P/2) clk = ~clk;

    audio_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .mclk_div2(mclk_div2),
        .fmt_lj(fmt_lj), .bus_hiz(bus_hiz), .sclk_in(sclk_in), .lrck_in(lrck_in),
        .sdin(sdin), .sclk_out(sclk_out), .lrck_out(lrck_out), .clk_oe(clk_oe),
        .left_data(left_data), .right_data(right_data), .sample_valid(sample_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] pad(input logic [23:0] w, input int s);
        return (s >= 24) ? w : (w & (24'hFFFFFF << (24 - s)));
    endfunction

    // Output monitor: compares each published pair and the strobe width.
    always @(negedge clk) begin
        if (mon_on && prev_v)
            chk(!sample_valid, "R8", "strobe longer than one cycle", 48'(sample_valid), 48'd0);
        if (mon_on && sample_valid) begin
            if (rx_idx == 0) first_t = $time;
            if (rx_idx < 8)
                chk({left_data, right_data} == {expL[rx_idx], expR[rx_idx]}, mon_req,
                    "stereo pair", {left_data, right_data}, {expL[rx_idx], expR[rx_idx]});
            rx_idx++;
        end
        prev_v = sample_valid;
    end

    task automatic do_reset(input bit m, input bit d, input bit f, input bit h);
        mon_on = 1'b0;
        rst_n = 1'b0;
        master_en = m; mclk_div2 = d; fmt_lj = f; bus_hiz = h;
        sclk_in = 1'b0; lrck_in = ~f; sdin = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        rel_t = $time;
        rx_idx = 0; prev_v = 1'b0; mon_on = 1'b1;
    endtask

    // Master-mode transmitter: drives sdin after each falling generated SCLK.
    task automatic master_tx(input bit f);
        bit last_lr = f;
        int pos = 0, fr = 0, k;
        logic [23:0] w;
        while (tx_run) begin
            @(negedge sclk_out);
            #1;
            if (lrck_out != last_lr) begin
                pos = 0;
                if (lrck_out == f) fr++;
            end else pos++;
            last_lr = lrck_out;
            w = (lrck_out == f) ? txL[fr % 8] : txR[fr % 8];
            k = f ? pos : pos - 1;
            sdin = (k >= 0 && k < 24) ? w[23-k] : 1'($urandom % 2);
        end
    endtask

    task automatic master_run(input bit f, input bit d, input bit h, input string req);
        int   tk = d ? 2 : 1;
        time  t0, t1;
        for (int i = 0; i < 8; i++) begin txL[i] = 24'($urandom); txR[i] = 24'($urandom); end
        for (int i = 0; i < 7; i++) begin expL[i] = txL[i+1]; expR[i] = txR[i+1]; end
        mon_req = req;
        tx_run = 1'b1;
        do_reset(1'b1, d, f, h);
        fork
            master_tx(f);
            begin
                @(posedge sclk_out); t0 = $time;
                @(posedge sclk_out); t1 = $time;
                chk((t1 - t0) == 2*tk*CLK_P, d ? "R2" : "R1", "sclk period",
                    48'(t1 - t0), 48'(2*tk*CLK_P));
                @(lrck_out); t0 = $time;
                @(lrck_out); t1 = $time;
                chk((t1 - t0) == 64*tk*CLK_P, d ? "R2" : "R1", "lrck half period",
                    48'(t1 - t0), 48'(64*tk*CLK_P));
                chk(clk_oe == !h, "R3", "master output enable", 48'(clk_oe), 48'(!h));
                for (int i = 0; i < 3000 && rx_idx < 4; i++) @(posedge clk);
                chk(rx_idx >= 4, req, "frames received", 48'(rx_idx), 48'd4);
                chk((first_t - rel_t) >= (256*tk - 4)*CLK_P && (first_t - rel_t) <= (256*tk + 10)*CLK_P,
                    "R10", "first frame dropped, first strobe time", 48'(first_t - rel_t), 48'(256*tk*CLK_P));
                mon_on = 1'b0;
                tx_run = 1'b0;
            end
        join
    endtask

    // One slave bit-clock period: word select and data change as SCLK falls.
    task automatic slave_period(input bit lr, input bit d);
        lrck_in = lr; sdin = d; sclk_in = 1'b0;
        repeat (4) @(posedge clk);
        #1 sclk_in = 1'b1;
        repeat (4) @(posedge clk);
        #1 sclk_in = 1'b0;
    endtask

    task automatic slave_slot(input bit f, input bit lr, input logic [23:0] w, input int s);
        bit b;
        for (int k = 0; k < s; k++) begin
            b = (k < 24) ? w[23-k] : 1'($urandom % 2);
            if (f) slave_period(lr, b);
            else begin slave_period(lr, carry); carry = b; end
        end
    endtask

    task automatic slave_run(input bit f, input int s, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            txL[i] = 24'($urandom); txR[i] = 24'($urandom);
            expL[i] = pad(txL[i], s); expR[i] = pad(txR[i], s);
        end
        mon_req = req;
        carry = 1'b0;
        do_reset(1'b0, 1'b0, f, 1'b0);
        chk(clk_oe == 1'b0, "R3", "slave output enable", 48'(clk_oe), 48'd0);
        slave_slot(f, ~f, 24'($urandom), s);
        for (int i = 0; i < n; i++) begin
            slave_slot(f, f, txL[i], s);
            slave_slot(f, ~f, txR[i], s);
        end
        slave_slot(f, f, 24'd0, s);
        repeat (20) @(posedge clk);
        chk(rx_idx == n, "R10", "frame count incl. dropped preamble", 48'(rx_idx), 48'(n));
        #1;
        chk({left_data, right_data} == {expL[n-1], expR[n-1]}, "R8", "outputs held",
            {left_data, right_data}, {expL[n-1], expR[n-1]});
        mon_on = 1'b0;
    endtask

    initial begin
        #(CLK_P * 190000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk({sample_valid, sclk_out, left_data, right_data} == '0, "R9", "reset state",
            48'({sample_valid, sclk_out, left_data[22:0]}), 48'd0);
        chk(right_data == '0, "R9", "reset right word", 48'(right_data), 48'd0);
        master_run(1'b0, 1'b0, 1'b0, "R4");
        master_run(1'b1, 1'b1, 1'b1, "R5");
        slave_run(1'b0, 32, 4, "R6");
        slave_run(1'b0, 24, 3, "R4");
        slave_run(1'b0, 16, 3, "R7");
        slave_run(1'b1, 32, 3, "R5");
        slave_run(1'b1, 20, 3, "R7");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule